// File: doc/BRIEF.md
# ROM Bank Decoder with Wait-State Generator

This block connects a 20-bit processor address bus to a group of eight 4 KB read-only memory chips. Together the chips fill the top 32 KB of the 1 MB space, from F8000h to FFFFFh. The processor pulses an address-latch strobe while it drives an address, and the block captures the address at that moment. When the active-low read strobe is then asserted and the captured address falls in the region, the block pulls exactly one of eight active-low chip selects low. It also drives the memories' active-low output enable, so their three-state data outputs reach the bus only during that read.

The memory access time plus the decode delay is longer than the processor's normal read window. For this reason the block drops a ready signal for one clock at the start of every read that hits the region. This adds a single wait state. Reads to any other address see no wait state and no select. All outputs are registered. Reset is synchronous and active high.

Top module: `rom_bank_decoder`

## Requirements
- R1: While reset is high, and on the first clock after it, every chip select is high (inactive), the output enable is high and ready is high.
- R2: A rising edge of the clock with `ale` high captures `addr`. Changes on `addr` while `ale` is low do not affect decoding.
- R3: When the captured address has bits 19..15 all ones and `rd_n` is sampled low at a clock edge, `cs_n[k]` is low after that edge, where k is captured bits 14..12. All other selects stay high.
- R4: Chip k answers over the full range F8000h + k·1000h through F8FFFh + k·1000h. Both the first and the last address of each chip select chip k.
- R5: A read with a captured address outside F8000h..FFFFFh (for example F7FFFh or 00000h) leaves every select high and the output enable high.
- R6: When `rd_n` is sampled high, every select and the output enable are high after that edge, even if the captured address is in the region.
- R7: The output enable `oe_n` is low after exactly those edges at which some select is low.
- R8: At the edge where a read to the region begins (`rd_n` sampled low after being high), ready goes low for exactly WAIT_CLKS clocks (default 1) and then returns high while the read continues.
- R9: Reads outside the region leave ready high throughout.
- R10: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (20) | Processor address bus |
| ale | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Memory-read strobe, active low |
| cs_n | output | 2**CHIP_SEL_W (8) | Chip selects, active low, one per chip |
| oe_n | output | 1 | Memory output enable, active low |
| ready | output | 1 | High when the access may finish; low during the wait state |

## Verification
The assertions check on every cycle that at most one select is low, that the output enable tracks the selects, that selects are released after any edge without a read, and that a ready-low stretch never exceeds the wait length and starts only together with a new region read. Only the bench scenarios show that the select index is correct for each chip's first and last address. The same holds for addresses just below F8000h, which must decode to nothing, and for bus changes after the latch strobe, which must be ignored. The bench also confirms that ready really drops on every region read and stays high on the others.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;
  localparam int DEF_ADDR_W     = 20;
  localparam int DEF_CHIP_AW    = 12;
  localparam int DEF_CHIP_SEL_W = 3;
  localparam int DEF_WAIT_CLKS  = 1;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WAIT  = 2'd1,
    ACC_READY = 2'd2
  } acc_state_e;
endpackage

// File: rtl/rom_addr_latch.sv
module rom_addr_latch #(
  parameter int ADDR_W  = rom_dec_pkg::DEF_ADDR_W,
  parameter int CHIP_AW = rom_dec_pkg::DEF_CHIP_AW,
  localparam int HI_W   = ADDR_W - CHIP_AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [HI_W-1:0] addr_hi,
  output logic [HI_W-1:0] lat_hi
);
  always_ff @(posedge clk) begin
    if (rst)      lat_hi <= '0;
    else if (ale) lat_hi <= addr_hi;
  end
endmodule

// File: rtl/rom_region_decode.sv
module rom_region_decode #(
  parameter int ADDR_W     = rom_dec_pkg::DEF_ADDR_W,
  parameter int CHIP_AW    = rom_dec_pkg::DEF_CHIP_AW,
  parameter int CHIP_SEL_W = rom_dec_pkg::DEF_CHIP_SEL_W,
  localparam int HI_W      = ADDR_W - CHIP_AW,
  localparam int TAG_W     = HI_W - CHIP_SEL_W,
  localparam int N_CHIPS   = 1 << CHIP_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HI_W-1:0]    lat_hi,
  input  logic               rd_n,
  output logic               hit,
  output logic [N_CHIPS-1:0] cs_n,
  output logic               oe_n
);
  logic [TAG_W-1:0]      tag;
  logic [CHIP_SEL_W-1:0] bank;
  logic [N_CHIPS-1:0]    sel_d;
  logic                  rd_hit;

  assign tag    = lat_hi[HI_W-1 -: TAG_W];
  assign bank   = lat_hi[CHIP_SEL_W-1:0];
  assign hit    = (tag == {TAG_W{1'b1}});
  assign rd_hit = hit && !rd_n;

  for (genvar k = 0; k < N_CHIPS; k++) begin : g_sel
    assign sel_d[k] = !(rd_hit && (bank == CHIP_SEL_W'(k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= '1;
      oe_n <= 1'b1;
    end else begin
      cs_n <= sel_d;
      oe_n <= !rd_hit;
    end
  end
endmodule

// File: rtl/rom_wait_gen.sv
module rom_wait_gen #(
  parameter int WAIT_CLKS = rom_dec_pkg::DEF_WAIT_CLKS,
  localparam int CNT_W    = $clog2(WAIT_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic rd_n,
  output logic ready
);
  import rom_dec_pkg::*;

  acc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             rd_q;
  logic             start;

  assign start = hit && !rd_n && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      cnt   <= '0;
      state <= ACC_IDLE;
      ready <= 1'b1;
    end else begin
      rd_q <= !rd_n;
      if (start) begin
        cnt   <= CNT_W'(WAIT_CLKS - 1);
        state <= ACC_WAIT;
        ready <= 1'b0;
      end else if (state == ACC_WAIT && cnt != '0) begin
        cnt   <= cnt - 1'b1;
        ready <= 1'b0;
      end else begin
        state <= (rd_n) ? ACC_IDLE : ACC_READY;
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder #(
  parameter int ADDR_W     = rom_dec_pkg::DEF_ADDR_W,
  parameter int CHIP_AW    = rom_dec_pkg::DEF_CHIP_AW,
  parameter int CHIP_SEL_W = rom_dec_pkg::DEF_CHIP_SEL_W,
  parameter int WAIT_CLKS  = rom_dec_pkg::DEF_WAIT_CLKS,
  localparam int HI_W      = ADDR_W - CHIP_AW,
  localparam int N_CHIPS   = 1 << CHIP_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ale,
  input  logic               rd_n,
  output logic [N_CHIPS-1:0] cs_n,
  output logic               oe_n,
  output logic               ready
);
  logic [HI_W-1:0] lat_hi;
  logic            hit;
  logic            unused_low;

  assign unused_low = ^addr[CHIP_AW-1:0];

  rom_addr_latch #(.ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW)) u_latch (
    .clk(clk), .rst(rst), .ale(ale),
    .addr_hi(addr[ADDR_W-1:CHIP_AW]), .lat_hi(lat_hi)
  );

  rom_region_decode #(.ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW), .CHIP_SEL_W(CHIP_SEL_W)) u_dec (
    .clk(clk), .rst(rst), .lat_hi(lat_hi), .rd_n(rd_n),
    .hit(hit), .cs_n(cs_n), .oe_n(oe_n)
  );

  rom_wait_gen #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk(clk), .rst(rst), .hit(hit), .rd_n(rd_n), .ready(ready)
  );
endmodule

// File: rtl/rom_bank_decoder_chk.sv
module rom_bank_decoder_chk #(
  parameter int N_CHIPS   = 8,
  parameter int WAIT_CLKS = 1,
  localparam int RUN_W    = $clog2(WAIT_CLKS + 2)
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_n,
  input logic [N_CHIPS-1:0] cs_n,
  input logic               oe_n,
  input logic               ready
);
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                                 low_run <= '0;
    else if (ready)                          low_run <= '0;
    else if (low_run != RUN_W'(WAIT_CLKS+1)) low_run <= low_run + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cs_n == '1 && oe_n && ready));

  p_idle_release_r6: assert property (@(posedge clk) disable iff (rst)
    rd_n |=> (cs_n == '1 && oe_n));

  p_oe_follows_sel_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) == !oe_n);

  p_wait_len_r8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (low_run < RUN_W'(WAIT_CLKS)));

  p_wait_on_hit_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $fell(oe_n));

  p_single_sel_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
endmodule

bind rom_bank_decoder rom_bank_decoder_chk #(.N_CHIPS(N_CHIPS), .WAIT_CLKS(WAIT_CLKS)) u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .cs_n(cs_n), .oe_n(oe_n), .ready(ready)
);

// File: tb/rom_bank_decoder_test.sv
module rom_bank_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        ale = 1'b0;
  logic        rd_n = 1'b1;
  logic [7:0]  cs_n;
  logic        oe_n;
  logic        ready;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rom_bank_decoder uut (
    .clk(clk), .rst(rst), .addr(addr), .ale(ale), .rd_n(rd_n),
    .cs_n(cs_n), .oe_n(oe_n), .ready(ready)
  );

  function automatic logic in_region(input logic [19:0] a);
    return a[19:15] == 5'h1F;
  endfunction

  function automatic logic [7:0] exp_cs(input logic [19:0] a);
    return in_region(a) ? ~(8'h01 << a[14:12]) : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // latch a, then read with bus driven to junk
  task automatic do_read(input logic [19:0] a, input logic [19:0] junk, input string req);
    logic h;
    h = in_region(a);
    @(negedge clk); ale = 1'b1; addr = a; rd_n = 1'b1;
    @(negedge clk); ale = 1'b0; addr = junk; rd_n = 1'b0;
    @(negedge clk);
    chk({req, " sel"}, 32'(cs_n), 32'(exp_cs(a)));
    chk({req, " R7 oe"}, 32'(oe_n), 32'(!h));
    chk({req, h ? " R8 wait" : " R9 nowait"}, 32'(ready), 32'(!h));
    @(negedge clk);
    chk({req, " sel hold"}, 32'(cs_n), 32'(exp_cs(a)));
    chk({req, " R8 ready back"}, 32'(ready), 32'd1);
    rd_n = 1'b1;
    @(negedge clk);
    chk({req, " R6 release"}, 32'({cs_n, oe_n}), 32'h1FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset sel", 32'({cs_n, oe_n, ready}), 32'h3FF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 32'({cs_n, oe_n, ready}), 32'h3FF);

    for (int k = 0; k < 8; k++) begin
      do_read(20'hF8000 + 20'(k) * 20'h1000, 20'h00000, "R3 R4 first");
      do_read(20'hF8FFF + 20'(k) * 20'h1000, 20'h00000, "R3 R4 last");
    end

    do_read(20'hF7FFF, 20'hFFFFF, "R5 R2 below");
    do_read(20'hF0000, 20'hF8000, "R5 low");
    do_read(20'h00000, 20'h00000, "R5 zero");
    do_read(20'hFA123, 20'h00000, "R2 junk ignored");

    // R6: in-region address latched, no read strobe
    @(negedge clk); ale = 1'b1; addr = 20'hFC000;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
    chk("R6 no strobe", 32'({cs_n, oe_n, ready}), 32'h3FF);
    @(negedge clk);
    chk("R6 no strobe 2", 32'({cs_n, oe_n, ready}), 32'h3FF);

    for (int i = 0; i < 40; i++) begin
      logic [19:0] a;
      a = 20'($urandom);
      if ($urandom % 2 == 0) a[19:15] = 5'h1F;
      do_read(a, 20'($urandom), "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule